// File: doc/BRIEF.md
# I2C Master Byte-Count Transfer Controller

This block drives an I2C bus as the only master. Software programs a slave address, a byte count, a transmit byte and a control word. Setting the start bit then makes the controller produce a START, the address byte, the data bytes with their acknowledge slots, and optionally a STOP. The SCL and SDA outputs are pull-low enables for open-drain pads. Received data comes back through the serial data input.

A 16-bit down counter is loaded from the count register when START is issued and drops by one after each data byte. Reaching zero decides whether the controller NACKs in receive mode. It also decides whether the controller issues STOP or parks the bus with SCL held low to wait for a repeated START. In repeat mode the counter no longer ends the transfer, and the stop bit does. A halt input stands for a debug breakpoint: unless free-run is set, it freezes the bus at an SCL-low point.

Top module: `i2c_bytecount_master`

## Requirements
- R1: After reset every control, count, address and data register reads 0 and both pad enables are low. In the control word (read/write select 0), bits 31..16 and bit 12 always read 0 and ignore writes; all other bits 15..0 read back as written.
- R2: With master (control bit 10) and enable (bit 5) both set, writing start (bit 13) produces START and then the address byte {address[6:0], R/W}, where R/W = 1 when transmit (bit 9) is 0. The start bit reads 0 once START is done. When master or enable is 0, the start bit produces no bus activity.
- R3: The counter (read select 1, bits 31..16) is loaded from the count register (select 1, bits 15..0) at START and decrements after each data byte. With repeat mode 0 and stop (bit 11) set, STOP follows the byte that brings the counter to 0, and the stop bit then reads 0.
- R4: In master receive, each byte is ACKed except the one that brings the counter to 0, which is NACKed. The last received byte reads back at select 3, bits 15..8.
- R5: If force-NACK (bit 15) is set before the rising SCL of a received byte's last bit, that byte is NACKed and force-NACK then reads 0.
- R6: With free-run (bit 14) at 0, asserting halt stops the controller at the next SCL-low point. SCL stays low and SDA stays unchanged until halt is released, and the transfer then completes normally.
- R7: With free-run at 1, halt has no effect on the transfer.
- R8: If the address byte is NACKed, the NACK flag (select 2, bit 8) becomes 1 and no data byte is sent. With stop set, STOP follows.
- R9: With repeat mode (bit 7) at 0 and stop at 0, a counter of 0 leaves SCL held low and busy (select 2, bit 9) at 1. A later start gives a repeated START, and a later stop gives STOP.
- R10: With repeat mode at 1, the counter does not end the transfer. Bytes continue until stop is set, and STOP follows the byte then in progress.
- R11: SDA changes while SCL is high only as a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 control, 1 count, 2 slave address, 3 transmit byte |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read select, same map as writes |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| halt | input | 1 | Debug breakpoint request |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Register reads are combinational and are sampled one time unit after a falling clock edge in the same cycle as the select. Control writes land on the following rising edge. A START begins one clock after the start bit is written. Every bus phase lasts DIV clocks, so a byte with its acknowledge slot takes 36*DIV clocks. Because the exact end of a transfer depends on the count, the bench polls the busy bit with a bounded wait and takes every post-transfer reading only after busy has fallen. The halt checks first wait longer than one full bit time, so that the controller has reached SCL low before the bus is sampled.

// File: rtl/i2c_bytecount_master.sv
module i2c_bytecount_master #(
  parameter int DIV = 4,
  parameter int CW  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        halt,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [15:0] WMASK = 16'hEFFF;
  localparam int B_FNACK = 15, B_FREE = 14, B_STT = 13, B_STP = 11;
  localparam int B_MST = 10, B_TRX = 9, B_RM = 7, B_EN = 5;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_HOLD, S_STOP} st_t;

  st_t            state;
  logic [15:0]    ctl;
  logic [CW-1:0]  cnt_ld, cnt, nxt_cnt;
  logic [6:0]     sa;
  logic [7:0]     txb, rxb, sh;
  logic [DW-1:0]  dcnt;
  logic [2:0]     bitn;
  logic [1:0]     ph;
  logic           addrph, nack_lat, slv_ack, nackf;

  wire busy    = state != S_IDLE;
  wire parked  = state == S_IDLE || state == S_HOLD;
  wire frozen  = halt && !ctl[B_FREE] && scl_oe;
  wire tick    = dcnt == DW'(DIV - 1);
  wire adv     = tick && !frozen && !parked;
  wire rx_mode = !ctl[B_TRX] && !addrph;
  wire go      = ctl[B_STT] && ctl[B_MST] && ctl[B_EN];
  wire fail    = !rx_mode && !slv_ack;
  wire done    = !ctl[B_RM] && nxt_cnt == '0;
  wire brk     = ctl[B_RM] && ctl[B_STP];
  wire unused_hi = ^wr_data[31:16];

  assign nxt_cnt = (addrph || cnt == '0) ? cnt : cnt - CW'(1);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {16'h0, ctl};
      2'd1:    rd_data = (32'(cnt) << 16) | 32'(cnt_ld);
      2'd2:    rd_data = {22'h0, busy, nackf, 1'b0, sa};
      default: rd_data = {16'h0, rxb, txb};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ctl <= '0; cnt_ld <= '0; cnt <= '0; sa <= '0;
      txb <= '0; rxb <= '0; sh <= '0; dcnt <= '0; bitn <= '0; ph <= '0;
      addrph <= 1'b0; nack_lat <= 1'b0; slv_ack <= 1'b0; nackf <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (parked || frozen) dcnt <= '0;
      else dcnt <= tick ? '0 : dcnt + 1'b1;
      if (adv) ph <= ph + 2'd1;
      case (state)
        S_IDLE: if (go) begin state <= S_START; ph <= '0; end
        S_HOLD: if (!frozen) begin
          if (go) begin state <= S_START; ph <= '0; end
          else if (ctl[B_STP]) begin state <= S_STOP; ph <= '0; end
        end
        S_START: if (adv) case (ph)
          2'd0: sda_oe <= 1'b0;
          2'd1: scl_oe <= 1'b0;
          2'd2: sda_oe <= 1'b1;
          default: begin
            scl_oe <= 1'b1; ctl[B_STT] <= 1'b0; cnt <= cnt_ld;
            sh <= {sa, !ctl[B_TRX]}; addrph <= 1'b1; bitn <= 3'd7;
            nackf <= 1'b0; state <= S_BIT;
          end
        endcase
        S_BIT: if (adv) case (ph)
          2'd0: sda_oe <= rx_mode ? 1'b0 : !sh[7];
          2'd1: begin
            scl_oe <= 1'b0;
            if (bitn == 3'd0)
              nack_lat <= ctl[B_FNACK] || (!ctl[B_RM] && cnt == CW'(1));
          end
          2'd2: if (rx_mode) sh <= {sh[6:0], sda_i};
          default: begin
            scl_oe <= 1'b1;
            if (!rx_mode) sh <= {sh[6:0], 1'b0};
            if (bitn == 3'd0) state <= S_ACK;
            else bitn <= bitn - 3'd1;
          end
        endcase
        S_ACK: if (adv) case (ph)
          2'd0: sda_oe <= rx_mode && !nack_lat;
          2'd1: scl_oe <= 1'b0;
          2'd2: slv_ack <= !sda_i;
          default: begin
            scl_oe <= 1'b1; bitn <= 3'd7; addrph <= 1'b0; cnt <= nxt_cnt;
            if (rx_mode) rxb <= sh;
            if (rx_mode && nack_lat) ctl[B_FNACK] <= 1'b0;
            if (fail) nackf <= 1'b1;
            if (fail || done || brk) state <= ctl[B_STP] ? S_STOP : S_HOLD;
            else begin state <= S_BIT; sh <= txb; end
          end
        endcase
        default: if (adv) case (ph)
          2'd0: sda_oe <= 1'b1;
          2'd1: scl_oe <= 1'b0;
          2'd2: sda_oe <= 1'b0;
          default: begin ctl[B_STP] <= 1'b0; state <= S_IDLE; end
        endcase
      endcase
      if (wr_en) case (wr_addr)
        2'd0:    ctl <= wr_data[15:0] & WMASK;
        2'd1:    cnt_ld <= wr_data[CW-1:0];
        2'd2:    sa <= wr_data[6:0];
        default: txb <= wr_data[7:0];
      endcase
    end
  end

  assert_stt_self_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && adv && ph == 2'd3 && !(wr_en && wr_addr == 2'd0))
      |=> (!ctl[B_STT] && state == S_BIT));

  assert_stp_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && adv && ph == 2'd3 && !(wr_en && wr_addr == 2'd0))
      |=> (!ctl[B_STP] && !busy && !scl_oe && !sda_oe));

  assert_last_byte_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK && adv && ph == 2'd0 && rx_mode && !ctl[B_RM] && cnt == CW'(1))
      |=> !sda_oe);

  assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (scl_oe && $stable(sda_oe)));

  assert_sda_quiet_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_BIT || state == S_ACK) && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));
endmodule

// File: tb/tb_i2c_bytecount_master.sv
`timescale 1ns/1ps
module tb_i2c_bytecount_master;
  localparam logic [6:0] SA = 7'h3A;
  localparam logic [31:0] C_EN = 32'h20, C_MST = 32'h400, C_STT = 32'h2000,
    C_STP = 32'h800, C_TRX = 32'h200, C_RM = 32'h80, C_FREE = 32'h4000, C_FNACK = 32'h8000;
  // {write, count, tx byte, expected bytes}
  localparam logic [24:0] VEC [4] = '{
    {1'b1, 8'd1, 8'hA5, 8'd1}, {1'b1, 8'd3, 8'h3C, 8'd3},
    {1'b0, 8'd1, 8'h00, 8'd1}, {1'b0, 8'd4, 8'h00, 8'd4}};

  logic clk = 0, rst_n = 0, wr_en = 0, halt = 0, clr = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic scl_oe, sda_oe, s_pull;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_pull);
  int checks = 0, errors = 0;
  bit finished = 0;

  i2c_bytecount_master dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .halt(halt),
    .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int k);
    return 8'hC3 ^ 8'(k * 17);
  endfunction

  // behavioural slave
  logic pscl = 1, psda = 1, act = 0, adrp = 0, stx = 0, stx_stop = 0, ackd = 0, rw = 0;
  logic [3:0] bc = 0, rd_idx = 0;
  logic [7:0] sh = 0, tbyte = 0, last_w = 0, wlimit = 8'hFF;
  logic [15:0] mack = 0;
  int bytes_w = 0, starts = 0, stops = 0, rises = 0, hi_chg = 0;
  initial s_pull = 0;
  always @(posedge clk) begin
    pscl <= scl_w; psda <= sda_w;
    if (scl_w && !pscl) rises <= rises + 1;
    if (scl_w && pscl && sda_w != psda) hi_chg <= hi_chg + 1;
    if (clr) begin
      bytes_w <= 0; starts <= 0; stops <= 0; hi_chg <= 0; mack <= 0; rd_idx <= 0;
      act <= 0; s_pull <= 0;
    end else if (scl_w && pscl && psda && !sda_w) begin
      act <= 1; bc <= 0; adrp <= 1; stx <= 0; stx_stop <= 0; ackd <= 0; s_pull <= 0;
      starts <= starts + 1;
    end else if (scl_w && pscl && !psda && sda_w) begin
      act <= 0; s_pull <= 0; stops <= stops + 1;
    end else if (act && scl_w && !pscl) begin
      if (bc < 8) begin
        if (!stx) sh <= {sh[6:0], sda_w};
        bc <= bc + 1;
      end else begin
        ackd <= 1;
        if (stx) begin
          mack[rd_idx] <= !sda_w;
          if (sda_w) stx_stop <= 1;
          rd_idx <= rd_idx + 1;
        end
      end
    end else if (act && !scl_w && pscl) begin
      if (bc == 8 && !ackd) begin
        if (stx) s_pull <= 0;
        else if (adrp) begin
          if (sh[7:1] == SA) begin s_pull <= 1; rw <= sh[0]; end
          else act <= 0;
        end else begin
          bytes_w <= bytes_w + 1; last_w <= sh;
          s_pull <= (bytes_w < int'(wlimit));
        end
      end else if (bc == 8) begin
        bc <= 0; ackd <= 0; s_pull <= 0;
        if (adrp) begin
          adrp <= 0;
          if (rw) begin stx <= 1; tbyte <= pat(int'(rd_idx)); s_pull <= !pat(int'(rd_idx))[7]; end
        end else if (stx && !stx_stop) begin
          tbyte <= pat(int'(rd_idx)); s_pull <= !pat(int'(rd_idx))[7];
        end
      end else if (stx && bc >= 1) begin
        s_pull <= stx_stop ? 1'b0 : !tbyte[7 - bc];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] actv, input logic [31:0] expv);
    checks++;
    if (actv !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic clear_stats();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd2, d);
      if (!d[9]) break;
    end
  endtask

  task automatic setup(input logic [6:0] a, input int n, input logic [7:0] tx);
    clear_stats();
    wr(2'd2, 32'(a)); wr(2'd1, 32'(n)); wr(2'd3, 32'(tx));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [24:0] v;
    int n, r0;
    logic s0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, d); check("R1 ctl reset", d, 0);
    rd(2'd1, d); check("R1 count reset", d, 0);
    rd(2'd2, d); check("R1 addr reset", d, 0);
    rd(2'd3, d); check("R1 data reset", d, 0);
    check("R1 pads released", {scl_oe, sda_oe}, 0);
    // R1 reserved bits
    wr(2'd0, 32'hFFFF_1FFF); rd(2'd0, d); check("R1 reserved masked", d, 32'h0FFF);
    wr(2'd0, 0);
    // R2 gating without master/enable
    setup(SA, 1, 8'h11);
    wr(2'd0, C_STT | C_STP); repeat (300) @(negedge clk);
    check("R2 no start when gated", starts, 0);
    check("R2 bus idle when gated", scl_w, 1);
    wr(2'd0, 0);

    for (int i = 0; i < 4; i++) begin
      v = VEC[i]; n = int'(v[23:16]);
      setup(SA, n, v[15:8]);
      wr(2'd0, C_EN | C_MST | C_STT | C_STP | (v[24] ? C_TRX : 0));
      wait_idle();
      check("R2 one START", starts, 1);
      check("R3 one STOP", stops, 1);
      rd(2'd0, d); check("R2 R3 start and stop self-clear", d & (C_STT | C_STP), 0);
      rd(2'd1, d); check("R3 counter at zero", d[31:16], 0);
      rd(2'd2, d); check("R8 no nack flag", d[8], 0);
      check("R11 sda edges with scl high", hi_chg, 2);
      if (v[24]) begin
        check("R2 bytes written", bytes_w, 32'(v[7:0]));
        check("R2 last byte", last_w, v[15:8]);
      end else begin
        check("R4 ack pattern", 32'(mack) & ((32'd1 << n) - 1), (32'd1 << (n - 1)) - 1);
        rd(2'd3, d); check("R4 last rx byte", d[15:8], pat(n - 1));
      end
    end

    // R8 address NACK
    setup(7'h11, 2, 8'h22);
    wr(2'd0, C_EN | C_MST | C_STT | C_STP | C_TRX); wait_idle();
    rd(2'd2, d); check("R8 nack flag", d[8], 1);
    check("R8 stop issued", stops, 1);
    check("R8 no data bytes", bytes_w, 0);

    // R9 hold then repeated START
    setup(SA, 2, 8'h5A);
    wr(2'd0, C_EN | C_MST | C_STT | C_TRX);
    for (int i = 0; i < 5000 && bytes_w < 2; i++) @(negedge clk);
    repeat (300) @(negedge clk);
    rd(2'd2, d); check("R9 still busy", d[9], 1);
    check("R9 scl held low", scl_w, 0);
    check("R9 no stop yet", stops, 0);
    wr(2'd1, 1);
    wr(2'd0, C_EN | C_MST | C_STT | C_TRX | C_STP); wait_idle();
    check("R9 repeated start", starts, 2);
    check("R9 total bytes", bytes_w, 3);
    check("R9 stop after restart", stops, 1);

    // R5 force NACK on first received byte
    setup(SA, 3, 8'h00);
    wr(2'd0, C_EN | C_MST | C_STT | C_STP | C_FNACK); wait_idle();
    check("R5 forced nack pattern", 32'(mack[2:0]), 32'b010);
    rd(2'd0, d); check("R5 force-nack cleared", d[15], 0);

    // R6 halt freezes at SCL low
    setup(SA, 2, 8'h96);
    wr(2'd0, C_EN | C_MST | C_STT | C_STP | C_TRX);
    repeat (200) @(negedge clk);
    halt = 1;
    repeat (40) @(negedge clk);
    r0 = rises; s0 = sda_w;
    repeat (400) @(negedge clk);
    check("R6 scl low during halt", scl_w, 0);
    check("R6 no scl pulses during halt", rises, r0);
    check("R6 sda stable during halt", sda_w, s0);
    halt = 0; wait_idle();
    check("R6 transfer completes", bytes_w, 2);

    // R7 free-run ignores halt
    setup(SA, 2, 8'h69);
    halt = 1;
    wr(2'd0, C_EN | C_MST | C_STT | C_STP | C_TRX | C_FREE); wait_idle();
    halt = 0;
    check("R7 bytes with halt", bytes_w, 2);
    check("R7 stop with halt", stops, 1);

    // R10 repeat mode ignores the counter
    setup(SA, 1, 8'h0F);
    wr(2'd0, C_EN | C_MST | C_STT | C_TRX | C_RM);
    for (int i = 0; i < 5000 && bytes_w < 3; i++) @(negedge clk);
    check("R10 continues past count", 32'(bytes_w >= 3), 1);
    check("R10 no stop before stop bit", stops, 0);
    wr(2'd0, C_EN | C_MST | C_TRX | C_RM | C_STP); wait_idle();
    check("R10 stop after stop bit", stops, 1);
    rd(2'd0, d); check("R10 stop bit cleared", d[11], 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule